// File: doc/BRIEF.md
# Capture/Compare Timer Status Flags

This block is a 16-bit free-running counter with two input-capture channels, two output-compare channels and a counter-overflow indicator. Five hardware events raise five sticky status flags. The flags appear together in one status byte on a byte-wide register bus that has separate read and write strobes.

A flag cannot be cleared by writing to it or by reading it once. Software must first read the status byte while the flag is 1, which arms that flag. Software must then read or write the low byte of the register that belongs to that flag. Only this second access clears the flag. Reset leaves the flags exactly as they were, and it drops any pending arming.

Top module: `cc_timer_status`

## Requirements
- R1: A read of address 0x13 returns the status byte. Bit 7 is the channel-1 capture flag, bit 6 the compare-1 flag, bit 5 the overflow flag, bit 4 the channel-2 capture flag and bit 3 the compare-2 flag. Bits 2..0 read as 0.
- R2: The counter resets to 0x0000. It adds one on each clock where `cnt_en` is 1 and holds its value otherwise. Its high byte reads at 0x18 and its low byte at 0x19.
- R3: The overflow flag sets on the clock edge where the counter steps from 0xFFFF to 0x0000.
- R4: Compare register 1 is written as bytes at 0x16 (high) and 0x17 (low). Compare register 2 is written at 0x1E (high) and 0x1F (low). Both reset to 0xFFFF. Compare flag n sets on the edge where the counter advances to a value equal to compare register n.
- R5: The channel-1 capture flag sets on an edge of `cap_in1`. `cap1_rise_sel`=1 selects the rising edge and 0 selects the falling edge. On the same clock edge, the current counter value is latched into capture register 1 (0x14 high, 0x15 low). The flag and the register update on the third rising clock edge after the input changes. Edges of the other direction change nothing.
- R6: The channel-2 capture flag sets only on a falling edge of `cap_in2`, with the same latency as R5. The counter value is latched into capture register 2 (0x1C high, 0x1D low).
- R7: A status read while a flag is 1 arms that flag. A later read or write of the flag's low byte clears it: 0x15 for capture 1, 0x17 for compare 1, 0x19 for overflow, 0x1D for capture 2 and 0x1F for compare 2.
- R8: A low-byte access to an unarmed flag leaves that flag unchanged. This includes the case where the status read happened while the flag was still 0.
- R9: If a set event and an arming low-byte access fall on the same clock, the flag stays 1 and the arming is used up.
- R10: Reset does not alter any flag, and it cancels any arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cnt_en | input | 1 | Counter clock enable |
| cap1_rise_sel | input | 1 | Channel-1 edge select: 1 selects rising, 0 selects falling |
| cap_in1 | input | 1 | Capture input, channel 1 (asynchronous) |
| cap_in2 | input | 1 | Capture input, channel 2 (asynchronous) |
| bus_addr | input | 8 | Register byte address |
| bus_rd | input | 1 | Read strobe, one access per clock |
| bus_wr | input | 1 | Write strobe, one access per clock |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |

## Verification
The edge-pulse property assumes that `cap1_rise_sel` changes only while the channel-1 synchronizer is settled, and that each capture input holds its level for at least three clocks. The stimulus therefore changes the select line only between capture events and waits four clocks after every input transition. The flag properties assume that `bus_rd` and `bus_wr` are never high together. The bench raises a strobe for exactly one clock per access and observes the flags without a strobe, so observing never arms or clears a flag.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int DW    = 8;
  localparam int CW    = 2 * DW;
  localparam int AW    = 8;
  localparam int NFLAG = 5;
  localparam int NCH   = 2;

  localparam logic [AW-1:0] A_STAT   = 8'h13;
  localparam logic [AW-1:0] A_CAP1_H = 8'h14;
  localparam logic [AW-1:0] A_CAP1_L = 8'h15;
  localparam logic [AW-1:0] A_CMP1_H = 8'h16;
  localparam logic [AW-1:0] A_CMP1_L = 8'h17;
  localparam logic [AW-1:0] A_CNT_H  = 8'h18;
  localparam logic [AW-1:0] A_CNT_L  = 8'h19;
  localparam logic [AW-1:0] A_CAP2_H = 8'h1C;
  localparam logic [AW-1:0] A_CAP2_L = 8'h1D;
  localparam logic [AW-1:0] A_CMP2_H = 8'h1E;
  localparam logic [AW-1:0] A_CMP2_L = 8'h1F;

  // flag index = status bit - (DW - NFLAG)
  typedef enum int {FI_CMP2 = 0, FI_CAP2 = 1, FI_OVF = 2, FI_CMP1 = 3, FI_CAP1 = 4} flag_idx_e;

  // low-byte address that completes each flag's clear, indexed by flag_idx_e
  localparam logic [NFLAG-1:0][AW-1:0] FLAG_LO_A = {A_CAP1_L, A_CMP1_L, A_CNT_L, A_CAP2_L, A_CMP2_L};

  // per-channel addresses, index 0 = channel 1
  localparam logic [NCH-1:0][AW-1:0] CMP_HI_A = {A_CMP2_H, A_CMP1_H};
  localparam logic [NCH-1:0][AW-1:0] CMP_LO_A = {A_CMP2_L, A_CMP1_L};
  localparam logic [NCH-1:0][AW-1:0] CAP_HI_A = {A_CAP2_H, A_CAP1_H};
  localparam logic [NCH-1:0][AW-1:0] CAP_LO_A = {A_CAP2_L, A_CAP1_L};
endpackage

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt,
  output logic         wrap
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_nxt = cnt_q + {{(W-1){1'b0}}, 1'b1};
    cnt_d   = en ? cnt_nxt : cnt_q;
    wrap    = en && (cnt_q == {W{1'b1}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> cnt_q == $past(cnt_q) + W'(1));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q));
endmodule

// File: rtl/cct_edge_det.sv
module cct_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic rise_sel,
  output logic pulse
);
  // [STAGES-1:0] synchronizer, [STAGES] one-cycle delayed copy
  logic [STAGES:0] pipe_q, pipe_d;
  logic            rise, fall;

  always_comb begin
    pipe_d = {pipe_q[STAGES-1:0], din};
    rise   = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    fall   = ~pipe_q[STAGES-1] & pipe_q[STAGES];
    pulse  = rise_sel ? rise : fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/cct_flag_cell.sv
module cct_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic stat_rd,
  input  logic low_acc,
  output logic flag_q
);
  logic armed_q, armed_d, flag_d;

  always_comb begin
    flag_d  = flag_q;
    armed_d = armed_q;
    if (stat_rd && flag_q) armed_d = 1'b1;
    if (low_acc) begin
      armed_d = 1'b0;
      if (armed_q) flag_d = 1'b0;
    end
    if (set_ev) flag_d = 1'b1;
  end

  // flag survives reset: no reset term
  always_ff @(posedge clk) begin
    flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag_q);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (low_acc && armed_q && !set_ev) |=> !flag_q);
  a_r8_unarmed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (low_acc && !armed_q && flag_q) |=> flag_q);
endmodule

// File: rtl/cc_timer_status.sv
module cc_timer_status
  import cct_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          cap1_rise_sel,
  input  logic          cap_in1,
  input  logic          cap_in2,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata
);
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          cnt_wrap;

  cct_counter #(.W(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cnt_en),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt),
    .wrap    (cnt_wrap)
  );

  logic [NCH-1:0]         cap_pulse, cmp_hit, cap_pin, edge_rise;
  logic [NCH-1:0][CW-1:0] cmp_q, cmp_d, cap_q, cap_d;

  assign cap_pin   = {cap_in2, cap_in1};
  assign edge_rise = {1'b0, cap1_rise_sel};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    cct_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (cap_pin[ch]),
      .rise_sel (edge_rise[ch]),
      .pulse    (cap_pulse[ch])
    );

    always_comb begin
      cmp_hit[ch] = cnt_en && (cnt_nxt == cmp_q[ch]);
      cmp_d[ch]   = cmp_q[ch];
      if (bus_wr && bus_addr == CMP_HI_A[ch]) cmp_d[ch][CW-1:DW] = bus_wdata;
      if (bus_wr && bus_addr == CMP_LO_A[ch]) cmp_d[ch][DW-1:0]  = bus_wdata;
      cap_d[ch]   = cap_pulse[ch] ? cnt_q : cap_q[ch];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_q[ch] <= '1;
        cap_q[ch] <= '0;
      end else begin
        cmp_q[ch] <= cmp_d[ch];
        cap_q[ch] <= cap_d[ch];
      end
    end

    a_r5_capture_latch: assert property (@(posedge clk) disable iff (!rst_n)
      cap_pulse[ch] |=> cap_q[ch] == $past(cnt_q));
    a_r4_compare_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && !bus_wr && (cnt_q + CW'(1)) == cmp_q[ch])
        |=> g_flag[ch == 0 ? FI_CMP1 : FI_CMP2].u_cell.flag_q);
  end

  logic [NFLAG-1:0] set_ev, low_acc, flag_q;
  logic             stat_rd;

  always_comb begin
    stat_rd          = bus_rd && (bus_addr == A_STAT);
    set_ev           = '0;
    set_ev[FI_CMP2]  = cmp_hit[1];
    set_ev[FI_CAP2]  = cap_pulse[1];
    set_ev[FI_OVF]   = cnt_wrap;
    set_ev[FI_CMP1]  = cmp_hit[0];
    set_ev[FI_CAP1]  = cap_pulse[0];
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign low_acc[i] = (bus_rd || bus_wr) && (bus_addr == FLAG_LO_A[i]);
    cct_flag_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_ev  (set_ev[i]),
      .stat_rd (stat_rd),
      .low_acc (low_acc[i]),
      .flag_q  (flag_q[i])
    );
  end

  always_comb begin
    case (bus_addr)
      A_STAT:   bus_rdata = {flag_q, {(DW-NFLAG){1'b0}}};
      A_CAP1_H: bus_rdata = cap_q[0][CW-1:DW];
      A_CAP1_L: bus_rdata = cap_q[0][DW-1:0];
      A_CMP1_H: bus_rdata = cmp_q[0][CW-1:DW];
      A_CMP1_L: bus_rdata = cmp_q[0][DW-1:0];
      A_CNT_H:  bus_rdata = cnt_q[CW-1:DW];
      A_CNT_L:  bus_rdata = cnt_q[DW-1:0];
      A_CAP2_H: bus_rdata = cap_q[1][CW-1:DW];
      A_CAP2_L: bus_rdata = cap_q[1][DW-1:0];
      A_CMP2_H: bus_rdata = cmp_q[1][CW-1:DW];
      A_CMP2_L: bus_rdata = cmp_q[1][DW-1:0];
      default:  bus_rdata = '0;
    endcase
  end

  a_r3_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && cnt_q == '1) |=> flag_q[FI_OVF]);
  a_r1_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_STAT) |-> bus_rdata[DW-NFLAG-1:0] == '0);
endmodule

// File: tb/cc_timer_status_tb_top.sv
`timescale 1ns/1ps
module cc_timer_status_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, cnt_en, sel, cin1, cin2, brd, bwr;
  logic [7:0] addr, wdata, rdata;
  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_cnt = 16'h0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cc_timer_status dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cap1_rise_sel(sel),
    .cap_in1(cin1), .cap_in2(cin2), .bus_addr(addr), .bus_rd(brd),
    .bus_wr(bwr), .bus_wdata(wdata), .bus_rdata(rdata)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic peek16(input logic [7:0] ahi, output logic [15:0] d);
    logic [7:0] h, l;
    peek(ahi, h); peek(ahi + 8'd1, l); d = {h, l};
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); addr = a; brd = 1'b1;
    @(negedge clk); brd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; bwr = 1'b1;
    @(negedge clk); bwr = 1'b0;
  endtask

  task automatic run_cnt(input int n);
    @(negedge clk); cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
    exp_cnt = exp_cnt + 16'(n);
  endtask

  task automatic stat_is(input string req, input logic [7:0] exp);
    logic [7:0] s;
    peek(8'h13, s); chk(req, {8'h0, s}, {8'h0, exp});
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] last_cap;
    rst_n = 1'b0; cnt_en = 1'b0; sel = 1'b1; cin1 = 1'b0; cin2 = 1'b1;
    brd = 1'b0; bwr = 1'b0; addr = 8'h0; wdata = 8'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    peek16(8'h18, v); chk("R2 reset count", v, 16'h0000);
    peek16(8'h16, v); chk("R4 cmp1 reset", v, 16'hFFFF);
    peek16(8'h1E, v); chk("R4 cmp2 reset", v, 16'hFFFF);

    // put the undefined power-on flags into a known state
    rd(8'h13); rd(8'h15); rd(8'h17); rd(8'h19); rd(8'h1D); rd(8'h1F);
    stat_is("R7 all cleared", 8'h00);

    wr(8'h16, 8'h00); wr(8'h17, 8'h05);
    wr(8'h1E, 8'h00); wr(8'h1F, 8'h03);
    run_cnt(3);
    peek16(8'h18, v); chk("R2 count 3", v, exp_cnt);
    stat_is("R4 cmp2 match", 8'h08);
    run_cnt(2);
    stat_is("R4 cmp1 match", 8'h48);

    rd(8'h1F);
    stat_is("R8 unarmed access", 8'h48);
    rd(8'h13); rd(8'h1F);
    stat_is("R7 cmp2 cleared", 8'h40);
    rd(8'h17);
    stat_is("R7 cmp1 cleared", 8'h00);

    // arming attempt while flag is 0
    rd(8'h13);
    wr(8'h17, 8'h06);
    run_cnt(1);
    stat_is("R4 cmp1 match 6", 8'h40);
    rd(8'h17);
    stat_is("R8 stale status read", 8'h40);
    rd(8'h13); rd(8'h17);
    stat_is("R7 cmp1 cleared again", 8'h00);

    // channel 1 sweep over edge select and edge direction
    last_cap = 16'h0000;
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 2; d++) begin
        logic hit;
        run_cnt(3);
        @(negedge clk); sel = s[0];
        @(negedge clk); cin1 = ~cin1;
        hit = (cin1 == sel);
        repeat (2) @(negedge clk);
        stat_is("R5 latency not yet", 8'h00);
        @(negedge clk);
        stat_is("R5 capture flag", hit ? 8'h80 : 8'h00);
        if (hit) last_cap = exp_cnt;
        peek16(8'h14, v); chk("R5 capture value", v, last_cap);
        rd(8'h13); rd(8'h15);
        stat_is("R7 cap1 cleared", 8'h00);
      end
    end

    // channel 2: falling only, selector has no effect
    last_cap = 16'h0000;
    for (int d = 0; d < 2; d++) begin
      run_cnt(5);
      @(negedge clk); cin2 = ~cin2;
      repeat (3) @(negedge clk);
      stat_is("R6 capture flag", cin2 ? 8'h00 : 8'h10);
      if (!cin2) last_cap = exp_cnt;
      peek16(8'h1C, v); chk("R6 capture value", v, last_cap);
      rd(8'h13); rd(8'h1D);
      stat_is("R7 cap2 cleared", 8'h00);
    end

    // R9: set coincides with arming access
    v = exp_cnt + 16'd1;
    wr(8'h16, v[15:8]); wr(8'h17, v[7:0]);
    run_cnt(1);
    stat_is("R4 cmp1 set for R9", 8'h40);
    rd(8'h13);
    v = exp_cnt + 16'd256;
    wr(8'h16, v[15:8]);
    run_cnt(255);
    @(negedge clk); cnt_en = 1'b1; addr = 8'h17; brd = 1'b1;
    @(negedge clk); cnt_en = 1'b0; brd = 1'b0;
    exp_cnt = exp_cnt + 16'd1;
    peek16(8'h18, v); chk("R9 count at match", v, exp_cnt);
    stat_is("R9 set wins", 8'h40);
    rd(8'h17);
    stat_is("R9 arming consumed", 8'h40);
    rd(8'h13); rd(8'h17);
    stat_is("R7 cleared after R9", 8'h00);

    // R10: reset keeps flags, drops arming
    v = exp_cnt + 16'd1;
    wr(8'h16, v[15:8]); wr(8'h17, v[7:0]);
    run_cnt(1);
    rd(8'h13);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    exp_cnt = 16'h0;
    @(negedge clk);
    stat_is("R10 flag kept over reset", 8'h40);
    peek16(8'h18, v); chk("R2 count after reset", v, 16'h0000);
    rd(8'h17);
    stat_is("R10 arming dropped", 8'h40);
    rd(8'h13); rd(8'h17);
    stat_is("R7 cleared after R10", 8'h00);

    // full counter sweep through the wrap
    for (int k = 0; k < 15; k++) begin
      run_cnt(4096);
      peek16(8'h18, v); chk("R2 sweep count", v, exp_cnt);
    end
    stat_is("R3 no overflow yet", 8'h00);
    run_cnt(4095);
    peek16(8'h18, v); chk("R2 count at top", v, 16'hFFFF);
    stat_is("R4 both compares at top", 8'h48);
    run_cnt(1);
    peek16(8'h18, v); chk("R3 count wrapped", v, 16'h0000);
    stat_is("R3 overflow set", 8'h68);
    rd(8'h13); rd(8'h19);
    stat_is("R7 overflow cleared", 8'h48);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule